// File: doc/BRIEF.md
# JPEG Stream Output Packer

This block sits between a JPEG entropy coder and an 8-bit camera output bus. The coder hands over encoded body bytes one at a time with a valid/ready handshake. The block buffers them in a small FIFO. It wraps each image in a start-of-image marker (FF D8) and an end-of-image marker (FF D9), and drives the bytes onto the bus with a data-enable that is high only while a real byte is present. The bus may run slower than the core clock. A `busTick` strobe marks each core cycle that begins a new bus slot.

An optional word-alignment mode is latched at the start of each frame. In that mode every enable burst is a whole number of 4-slot groups, and the frame is padded with A5h filler bytes after its end marker until its length is a multiple of four.

The coder cannot stall inside a coding unit. If it offers a byte while the FIFO is full, the frame is cut short. The buffered bytes are dropped and an FF FE truncation marker closes the frame in place of FF D9. A sticky error flag is raised and stays set until the host reads it. A byte total for each frame is latched for the host at the end marker.

Top module: `jpeg_out_packer`

## Requirements
- R1: After a start pulse, the bus carries FF D8, then the body bytes in the order they were accepted, then FF D9.
- R2: `outEn` is high exactly in the bus slots that carry a frame byte, and `outData` reads 00h in every slot where `outEn` is low.
- R3: When `pad4En` is high at the start pulse, filler bytes of value A5h follow FF D9 until the frame's byte total is a multiple of four. When it is low, no filler is sent.
- R4: In padded mode every high run of `outEn`, counted in bus slots, has a length that is a multiple of four.
- R5: `inReady` is low whenever no frame is open for input or the FIFO holds `FIFO_DEPTH` bytes, and high otherwise.
- R6: A byte offered while a frame is open and `inReady` is low is an overflow. The buffered body bytes are discarded, and the frame ends with FF FE instead of FF D9. A start marker that has not yet gone out is still sent first.
- R7: `errFlag` rises the cycle after an overflow and stays high until an `errRead` pulse, which clears it one cycle later. A new overflow in the same cycle takes priority over the clear.
- R8: Once a frame is closed for input, by its last byte or by an overflow, offered bytes are ignored and cause no error until the next accepted start pulse.
- R9: `byteCount` is 0 after reset. It changes only in the slot that carries the end marker's second byte (D9h or FEh). It then takes the number of bytes from FF D8 through that byte inclusive, with filler excluded.
- R10: A start pulse that arrives while a frame is still being taken in or sent out is ignored.
- R11: After reset, `outEn` is low, `outData` is 00h, `errFlag` is low and `inReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pad4En | input | 1 | Word-alignment mode request, sampled at the start pulse |
| frameStart | input | 1 | Start-of-frame pulse from the coder |
| inData | input | 8 | Encoded body byte |
| inValid | input | 1 | Body byte offered |
| inLast | input | 1 | Offered byte is the last body byte of the frame |
| inReady | output | 1 | FIFO can take a byte for the open frame |
| busTick | input | 1 | This cycle starts a new bus slot |
| outData | output | 8 | Bus data byte |
| outEn | output | 1 | Bus data enable |
| byteCount | output | COUNT_W | Latched byte total of the last frame |
| errFlag | output | 1 | Sticky overflow flag |
| errRead | input | 1 | Host read of the error flag; clears it |

## Verification
The bus outputs are registered. The byte chosen in a slot appears on `outData`/`outEn` at the same `busTick` edge that consumes it, so a body byte needs at least one core cycle in the FIFO before it can reach the bus. The bench samples the bus at the falling edge after every tick edge. It compares whole frames only after a settling window long enough for the slowest tick rate in use, which avoids predicting exact slot positions. `errFlag` is due one core cycle after the offending offer, and its clear is due one cycle after `errRead`. Both are checked at the next falling edge. `byteCount` is read once the stream has ended, since it is latched in the same slot as the end marker.

// File: rtl/jpk_pkg.sv
package jpk_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FF,
    SEL_D8,
    SEL_D9,
    SEL_FE,
    SEL_FIFO,
    SEL_PAD
  } byteSel_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SOI0,
    PH_SOI1,
    PH_BODY,
    PH_EOI1,
    PH_PAD
  } phase_e;

  typedef struct packed {
    logic     push;
    logic     pop;
    logic     flush;
    logic     emit;
    byteSel_e sel;
    logic     cntClear;
    logic     cntInc;
    logic     cntLatch;
  } pkStrobe_t;

  localparam logic [7:0] FILL_BYTE = 8'hA5;

endpackage

// File: rtl/jpk_ctrl.sv
module jpk_ctrl
  import jpk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pad4En,
  input  logic          frameStart,
  input  logic          inValid,
  input  logic          inLast,
  input  logic          busTick,
  input  logic          errRead,
  input  logic [CW-1:0] fifoCount,
  output pkStrobe_t     strb,
  output logic          inReady,
  output logic          errFlag,
  output logic          padMode
);

  phase_e     phase, nextPhase;
  logic       frameOpen, bodyDone, aborted;
  logic [1:0] posMod;
  logic [1:0] nextMod;
  logic       fifoFull, fifoEmpty;
  logic       startOk, overflow, accept;
  logic       aheadOk, canGo;

  assign fifoFull  = (fifoCount == CW'(DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign startOk   = frameStart && (phase == PH_IDLE);
  assign overflow  = frameOpen && inValid && fifoFull;
  assign accept    = frameOpen && inValid && !fifoFull;
  assign inReady   = frameOpen && !fifoFull;
  assign nextMod   = posMod + 2'd1;

  // A 4-slot group may only start when its remaining bytes are guaranteed.
  always_comb begin
    unique case (phase)
      PH_SOI0: aheadOk = (fifoCount >= CW'(2));
      PH_SOI1: aheadOk = (fifoCount >= CW'(3));
      PH_BODY: aheadOk = (fifoCount >= CW'(4));
      default: aheadOk = 1'b1;
    endcase
    aheadOk = aheadOk || bodyDone;
  end

  assign canGo = !padMode || (posMod != 2'd0) || aheadOk;

  always_comb begin
    nextPhase     = phase;
    strb          = '0;
    strb.sel      = SEL_NONE;
    strb.push     = accept;
    strb.flush    = overflow || startOk;
    strb.cntClear = startOk;
    if (busTick && canGo) begin
      unique case (phase)
        PH_SOI0: begin
          strb.emit = 1'b1;
          strb.sel  = SEL_FF;
          nextPhase = PH_SOI1;
        end
        PH_SOI1: begin
          strb.emit = 1'b1;
          strb.sel  = SEL_D8;
          nextPhase = PH_BODY;
        end
        PH_BODY: begin
          if (!fifoEmpty) begin
            strb.emit = 1'b1;
            strb.sel  = SEL_FIFO;
            strb.pop  = 1'b1;
          end else if (bodyDone) begin
            strb.emit = 1'b1;
            strb.sel  = SEL_FF;
            nextPhase = PH_EOI1;
          end
        end
        PH_EOI1: begin
          strb.emit     = 1'b1;
          strb.sel      = aborted ? SEL_FE : SEL_D9;
          strb.cntLatch = 1'b1;
          nextPhase     = (padMode && nextMod != 2'd0) ? PH_PAD : PH_IDLE;
        end
        PH_PAD: begin
          strb.emit = 1'b1;
          strb.sel  = SEL_PAD;
          nextPhase = (nextMod == 2'd0) ? PH_IDLE : PH_PAD;
        end
        default: ;
      endcase
    end
    strb.cntInc = strb.emit && (strb.sel != SEL_PAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      frameOpen <= 1'b0;
      bodyDone  <= 1'b0;
      aborted   <= 1'b0;
      padMode   <= 1'b0;
      posMod    <= '0;
    end else if (startOk) begin
      phase     <= PH_SOI0;
      frameOpen <= 1'b1;
      bodyDone  <= 1'b0;
      aborted   <= 1'b0;
      padMode   <= pad4En;
      posMod    <= '0;
    end else begin
      phase <= nextPhase;
      if (strb.emit) posMod <= nextMod;
      if (overflow) begin
        frameOpen <= 1'b0;
        bodyDone  <= 1'b1;
        aborted   <= 1'b1;
      end else if (accept && inLast) begin
        frameOpen <= 1'b0;
        bodyDone  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         errFlag <= 1'b0;
    else if (overflow) errFlag <= 1'b1;
    else if (errRead)  errFlag <= 1'b0;
  end

endmodule

// File: rtl/jpk_dpath.sv
module jpk_dpath
  import jpk_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         inData,
  input  logic               busTick,
  input  pkStrobe_t          strb,
  output logic [7:0]         outData,
  output logic               outEn,
  output logic [COUNT_W-1:0] byteCount,
  output logic [CW-1:0]      fifoCount
);

  logic [7:0]         mem [DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [7:0]         byteMux;
  logic [COUNT_W-1:0] runCnt;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
      unique case ({strb.push, strb.pop})
        2'b10:   fifoCount <= fifoCount + CW'(1);
        2'b01:   fifoCount <= fifoCount - CW'(1);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_FF:   byteMux = 8'hFF;
      SEL_D8:   byteMux = 8'hD8;
      SEL_D9:   byteMux = 8'hD9;
      SEL_FE:   byteMux = 8'hFE;
      SEL_FIFO: byteMux = mem[rdPtr];
      SEL_PAD:  byteMux = FILL_BYTE;
      default:  byteMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEn   <= 1'b0;
      outData <= '0;
    end else if (busTick) begin
      outEn   <= strb.emit;
      outData <= strb.emit ? byteMux : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      byteCount <= '0;
    end else begin
      if (strb.cntClear)    runCnt <= '0;
      else if (strb.cntInc) runCnt <= runCnt + COUNT_W'(1);
      if (strb.cntLatch)    byteCount <= runCnt + COUNT_W'(1);
    end
  end

endmodule

// File: rtl/jpeg_out_packer.sv
module jpeg_out_packer
  import jpk_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int COUNT_W    = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pad4En,
  input  logic               frameStart,
  input  logic [7:0]         inData,
  input  logic               inValid,
  input  logic               inLast,
  output logic               inReady,
  input  logic               busTick,
  output logic [7:0]         outData,
  output logic               outEn,
  output logic [COUNT_W-1:0] byteCount,
  output logic               errFlag,
  input  logic               errRead
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  pkStrobe_t     strb;
  logic [CW-1:0] fifoCount;
  logic          padMode;

  jpk_ctrl #(.DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pad4En(pad4En), .frameStart(frameStart),
    .inValid(inValid), .inLast(inLast), .busTick(busTick), .errRead(errRead),
    .fifoCount(fifoCount), .strb(strb), .inReady(inReady),
    .errFlag(errFlag), .padMode(padMode)
  );

  jpk_dpath #(.DEPTH(FIFO_DEPTH), .COUNT_W(COUNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .inData(inData), .busTick(busTick), .strb(strb),
    .outData(outData), .outEn(outEn), .byteCount(byteCount), .fifoCount(fifoCount)
  );

endmodule

// File: rtl/jpeg_out_packer_chk.sv
module jpeg_out_packer_chk #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               busTick,
  input logic               inValid,
  input logic               inReady,
  input logic               errRead,
  input logic               errFlag,
  input logic               outEn,
  input logic [7:0]         outData,
  input logic [COUNT_W-1:0] byteCount,
  input logic               padMode
);

  logic [1:0] runMod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runMod <= '0;
    else if (busTick) runMod <= outEn ? runMod + 2'd1 : 2'd0;
  end

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> outData == 8'h00);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busTick && !outEn && padMode) |-> runMod == 2'd0);

  // R7
  err_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(inValid && !inReady));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errRead) |=> errFlag);

  // R9
  count_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(byteCount) |-> (outEn && (outData == 8'hD9 || outData == 8'hFE)));

endmodule

bind jpeg_out_packer jpeg_out_packer_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busTick(busTick), .inValid(inValid),
  .inReady(inReady), .errRead(errRead), .errFlag(errFlag), .outEn(outEn),
  .outData(outData), .byteCount(byteCount), .padMode(padMode)
);

// File: tb/jpeg_out_packer_bench.sv
module jpeg_out_packer_bench;

  localparam int DEPTH = 16;
  localparam int CNTW  = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            pad4En = 1'b0;
  logic            frameStart = 1'b0;
  logic [7:0]      inData = '0;
  logic            inValid = 1'b0;
  logic            inLast = 1'b0;
  logic            inReady;
  logic            busTick = 1'b0;
  logic [7:0]      outData;
  logic            outEn;
  logic [CNTW-1:0] byteCount;
  logic            errFlag;
  logic            errRead = 1'b0;

  int tests = 0;
  int fails = 0;

  int         tickDiv = 1;
  int         tickPh = 0;
  logic       tickSeen = 1'b0;
  logic [7:0] capBuf [256];
  int         capN = 0;
  int         runLen = 0;
  int         badRuns = 0;
  int         noise = 0;
  logic [7:0] expBuf [256];
  int         expN = 0;

  always #10 clk = ~clk;

  jpeg_out_packer #(.FIFO_DEPTH(DEPTH), .COUNT_W(CNTW)) u_jpeg_out_packer (
    .clk(clk), .rstN(rstN), .pad4En(pad4En), .frameStart(frameStart),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .busTick(busTick), .outData(outData), .outEn(outEn),
    .byteCount(byteCount), .errFlag(errFlag), .errRead(errRead)
  );

  always @(negedge clk) begin
    if (tickDiv == 0) busTick = 1'b0;
    else begin
      busTick = (tickPh == 0);
      tickPh  = (tickPh + 1 >= tickDiv) ? 0 : tickPh + 1;
    end
  end

  always @(posedge clk) tickSeen <= busTick;

  always @(negedge clk) begin
    if (rstN && tickSeen) begin
      if (outEn) begin
        if (capN < 256) capBuf[capN] = outData;
        capN++;
        runLen++;
      end else begin
        if (outData != 8'h00) noise++;
        if (runLen != 0) begin
          if (runLen % 4 != 0) badRuns++;
          runLen = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCap();
    capN = 0; runLen = 0; badRuns = 0; noise = 0;
  endtask

  task automatic pushByte(input logic [7:0] b, input logic last);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = b; inLast = last;
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic pulseStart();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic compareStream(input string req);
    int firstBad;
    firstBad = -1;
    for (int i = 0; i < expN && i < capN; i++)
      if (firstBad < 0 && capBuf[i] !== expBuf[i]) firstBad = i;
    chk(capN == expN, {req, " length"}, capN, expN);
    if (firstBad >= 0) chk(1'b0, {req, " byte"}, int'(capBuf[firstBad]), int'(expBuf[firstBad]));
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic runFrame(input int n, input bit pad, input int div, input bit extraStart,
                          input string req);
    int total;
    clearCap();
    tickDiv = div; pad4En = pad;
    @(negedge clk);
    pulseStart();
    expN = 0;
    expBuf[expN++] = 8'hFF; expBuf[expN++] = 8'hD8;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 11) & 8'hFF);
      expBuf[expN++] = b;
      if (extraStart && i == 2) pulseStart();
      pushByte(b, i == n - 1);
    end
    expBuf[expN++] = 8'hFF; expBuf[expN++] = 8'hD9;
    total = expN;
    if (pad) while (expN % 4 != 0) expBuf[expN++] = 8'hA5;
    repeat (60 * (div < 1 ? 1 : div) + 40) @(negedge clk);
    compareStream(req);
    chk(byteCount == CNTW'(total), "R9 byte total", int'(byteCount), total);
    chk(noise == 0, "R2 idle bus data", noise, 0);
    if (pad) chk(badRuns == 0 && runLen == 0, "R4 burst multiple of four", badRuns, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(outEn == 1'b0, "R11 outEn", outEn, 0);
    chk(outData == 8'h00, "R11 outData", outData, 0);
    chk(errFlag == 1'b0, "R11 errFlag", errFlag, 0);
    chk(inReady == 1'b0, "R11/R5 inReady idle", inReady, 0);
    chk(byteCount == '0, "R9 reset count", int'(byteCount), 0);
  endtask

  task automatic t_overflow();
    clearCap();
    tickDiv = 0; pad4En = 1'b0;
    @(negedge clk);
    pulseStart();
    for (int i = 0; i < DEPTH; i++) pushByte(8'(i + 1), 1'b0);
    chk(inReady == 1'b0, "R5 full FIFO", inReady, 0);
    inValid = 1'b1; inData = 8'h55;
    @(negedge clk);
    inValid = 1'b0;
    chk(errFlag == 1'b1, "R7 flag set", errFlag, 1);
    chk(inReady == 1'b0, "R8 closed after overflow", inReady, 0);
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inData = 8'h77;
      @(negedge clk);
    end
    inValid = 1'b0;
    tickDiv = 1;
    repeat (60) @(negedge clk);
    expN = 4;
    expBuf[0] = 8'hFF; expBuf[1] = 8'hD8; expBuf[2] = 8'hFF; expBuf[3] = 8'hFE;
    compareStream("R6 truncated stream");
    chk(byteCount == CNTW'(4), "R9 truncated total", int'(byteCount), 4);
    chk(errFlag == 1'b1, "R7 sticky", errFlag, 1);
    errRead = 1'b1;
    @(negedge clk);
    errRead = 1'b0;
    chk(errFlag == 1'b0, "R7 cleared by read", errFlag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    runFrame(5, 1'b0, 1, 1'b0, "R1 plain frame");
    runFrame(5, 1'b0, 3, 1'b0, "R3 no filler when unpadded");
    runFrame(5, 1'b1, 1, 1'b0, "R3 padded 9 to 12");
    runFrame(6, 1'b1, 2, 1'b0, "R3 padded 10 to 12");
    runFrame(4, 1'b1, 1, 1'b0, "R3 already aligned");
    runFrame(1, 1'b1, 3, 1'b0, "R4 short padded frame");
    runFrame(40, 1'b0, 4, 1'b0, "R5 backpressure long frame");
    runFrame(30, 1'b1, 3, 1'b0, "R4 backpressure padded");
    runFrame(6, 1'b0, 1, 1'b1, "R10 start during frame");
    t_overflow();
    runFrame(3, 1'b0, 1, 1'b0, "R8 recovery frame");
    chk(errFlag == 1'b0, "R8 no error from ignored bytes", errFlag, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule